// File: doc/BRIEF.md
# Burst Bit Whitener

This block breaks up long runs of identical bits in a serial stream ahead of forward error correction. A 15-stage Fibonacci shift register generates a pseudorandom bit sequence. Each accepted data bit is XORed with the current sequence bit, and the result is presented one clock later. Because XOR is its own inverse, a second instance at the receiver, restarted at the same burst boundary, recovers the original bits.

A strobe marks the start of every burst. It puts the register back to a fixed seed, so each burst is whitened with the same sequence from its first bit. The register moves on only when a data bit is accepted. The stream may therefore pause for any number of cycles without losing alignment.

Top module: `burst_randomizer`

## Requirements
- R1: While rst_n is low, and in the cycle after it rises, out_valid and out_bit are 0. The register holds the seed, so a burst sent after reset without a start strobe is whitened as if it had been restarted.
- R2: For a cycle with in_valid high, the next cycle shows out_bit equal to in_bit XOR the sequence bit in effect in the accepting cycle.
- R3: out_valid equals in_valid delayed by exactly one clock cycle.
- R4: The register advances one step per cycle with in_valid high and holds in all other cycles. Idle gaps do not change the sequence applied to later bits.
- R5: If burst_start and in_valid are high in the same cycle, that bit is whitened with the first sequence bit of the seed. The following bits use the second, third and later sequence bits.
- R6: If burst_start is high while in_valid is low, the seed is reloaded and nothing is consumed. The next accepted bit uses the first sequence bit.
- R7: The feedback into stage 1 is stage 14 XOR stage 15. The seed is 100101010000000, with stage 1 written leftmost. The sequence bit is the XOR of the stages picked by the mask, and the default mask picks stages 14 and 15. With zero data, the first 30 output bits equal the recurrence u[i+15] = u[i] XOR u[i+1], where u[0..14] are stages 15 down to 1 of the seed.
- R8: Whitening a burst and then passing the result through the block again, after a fresh burst start, returns the original bits.
- R9: In a cycle following one with in_valid low, out_bit keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| burst_start | input | 1 | Reloads the seed; it may coincide with the first data bit |
| in_valid | input | 1 | Marks in_bit as a data bit to consume |
| in_bit | input | 1 | Serial data in |
| out_valid | output | 1 | Marks out_bit as whitened data |
| out_bit | output | 1 | Serial whitened data out |

## Verification
Reloading the seed and consuming a bit can fall in the same cycle, when burst_start arrives together with in_valid. In that case the bit must see the seed's sequence bit, and the register must leave the cycle one step past the seed. The stimulus table places this coincidence both at the head of a burst and in the middle of a running burst. A strobe without data, followed by a gap, is also placed in the table. Each output is compared with a bench model that counts accepted bits since the last reload and computes the sequence from a bit recurrence rather than from a shift register.

// File: rtl/brz_pkg.sv
package brz_pkg;
  localparam int unsigned REG_LEN = 15;

  typedef logic [REG_LEN-1:0] lfsr_t;

  // One Fibonacci step: stage k sits in bit k-1; feedback enters stage 1.
  function automatic lfsr_t lfsr_advance(input lfsr_t s,
                                         input int unsigned tap_near,
                                         input int unsigned tap_far);
    logic fb;
    fb = s[tap_near-1] ^ s[tap_far-1];
    return {s[REG_LEN-2:0], fb};
  endfunction

  // Sequence bit: parity of the stages chosen by the mask.
  function automatic logic mask_parity(input lfsr_t s, input lfsr_t m);
    return ^(s & m);
  endfunction
endpackage

// File: rtl/prbs_core.sv
module prbs_core
  import brz_pkg::*;
#(
  parameter lfsr_t       SEED     = 15'h00A9,
  parameter lfsr_t       MASK     = 15'h6000,
  parameter int unsigned TAP_NEAR = 14,
  parameter int unsigned TAP_FAR  = 15
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  logic  adv,
  output lfsr_t cur_state,
  output logic  seq_bit
);
  lfsr_t state_q;

  // State seen this cycle: a reload takes effect at once.
  assign cur_state = load ? SEED : state_q;
  assign seq_bit   = mask_parity(cur_state, MASK);

  always_ff @(posedge clk) begin
    if (!rst_n)    state_q <= SEED;
    else if (adv)  state_q <= lfsr_advance(cur_state, TAP_NEAR, TAP_FAR);
    else if (load) state_q <= SEED;
  end

  // R4: no accepted bit and no reload keeps the register still
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !load) |=> $stable(state_q));

  // R7: a maximal-length register never reaches the all-zero lockup state
  a_r7_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);
endmodule

// File: rtl/whiten_stage.sv
module whiten_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_bit,
  input  logic seq_bit,
  output logic out_valid,
  output logic out_bit
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_bit <= in_bit ^ seq_bit;
    end
  end

  a_r3_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r3_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r2_mix: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_bit == ($past(in_bit) ^ $past(seq_bit))));
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_bit));
endmodule

// File: rtl/burst_randomizer.sv
module burst_randomizer
  import brz_pkg::*;
#(
  parameter lfsr_t       SEED     = 15'h00A9,
  parameter lfsr_t       MASK     = 15'h6000,
  parameter int unsigned TAP_NEAR = 14,
  parameter int unsigned TAP_FAR  = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic burst_start,
  input  logic in_valid,
  input  logic in_bit,
  output logic out_valid,
  output logic out_bit
);
  lfsr_t cur_state;
  logic  seq_bit;
  logic  reload_only;

  assign reload_only = burst_start && !in_valid;

  prbs_core #(
    .SEED(SEED), .MASK(MASK), .TAP_NEAR(TAP_NEAR), .TAP_FAR(TAP_FAR)
  ) u_prbs (
    .clk(clk), .rst_n(rst_n), .load(burst_start), .adv(in_valid),
    .cur_state(cur_state), .seq_bit(seq_bit)
  );

  whiten_stage u_mix (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bit(in_bit),
    .seq_bit(seq_bit), .out_valid(out_valid), .out_bit(out_bit)
  );

  // R6: a strobe with no data leaves the seed waiting for the next bit
  a_r6_reload_only: assert property (@(posedge clk) disable iff (!rst_n)
    reload_only |=> (cur_state == SEED));

  // R5: a coincident strobe and bit always draws on the seed
  a_r5_first_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_start && in_valid) |-> (seq_bit == mask_parity(SEED, MASK)));
endmodule

// File: tb/test_burst_randomizer.sv
`timescale 1ns/1ps
module test_burst_randomizer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic burst_start = 1'b0, in_valid = 1'b0, in_bit = 1'b0;
  logic out_valid, out_bit;

  int checks = 0, errors = 0;
  int mdl_n = 0;
  logic mdl_out = 1'b0;
  bit finished = 0;

  localparam logic [14:0] SEED_TXT = 15'b100101010000000; // stage 1 leftmost

  // {burst_start, in_valid, in_bit}
  localparam logic [2:0] VEC [0:23] = '{
    3'b111, 3'b010, 3'b011, 3'b011, 3'b000, 3'b000, 3'b010, 3'b011,
    3'b100, 3'b000, 3'b011, 3'b010, 3'b110, 3'b011, 3'b000, 3'b011,
    3'b010, 3'b100, 3'b111, 3'b011, 3'b010, 3'b000, 3'b011, 3'b010};

  burst_randomizer i_burst_randomizer (
    .clk(clk), .rst_n(rst_n), .burst_start(burst_start), .in_valid(in_valid),
    .in_bit(in_bit), .out_valid(out_valid), .out_bit(out_bit));

  always #5 clk = ~clk;

  function automatic logic ref_seq(input int n);
    bit u [0:511];
    for (int i = 0; i < 15; i++) u[i] = SEED_TXT[i];
    for (int i = 0; i + 15 <= n + 15; i++) u[i+15] = u[i] ^ u[i+1];
    return u[n+15];
  endfunction

  task automatic check(input bit ok, input string req, input logic act, input logic exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic step(input logic bs, input logic v, input logic b, input string req);
    logic exp_b;
    @(negedge clk);
    burst_start = bs; in_valid = v; in_bit = b;
    if (bs) mdl_n = 0;
    exp_b = v ? (b ^ ref_seq(mdl_n)) : mdl_out;
    if (v) mdl_n++;
    @(posedge clk); #2;
    check(out_valid == v, {req, " valid"}, out_valid, v);
    check(out_bit == exp_b, {req, " data"}, out_bit, exp_b);
    mdl_out = exp_b;
  endtask

  task automatic report;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      report();
    end
  end

  initial begin
    logic sent [0:39];
    logic got  [0:39];
    // R1: reset state
    repeat (3) @(posedge clk);
    #2;
    check(out_valid == 1'b0, "R1 reset valid", out_valid, 1'b0);
    check(out_bit == 1'b0, "R1 reset data", out_bit, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #2;
    check(out_valid == 1'b0, "R1 after reset valid", out_valid, 1'b0);
    // R1: seed present without strobe
    step(1'b0, 1'b1, 1'b0, "R1 seed after reset");
    step(1'b0, 1'b1, 1'b1, "R1 seed after reset");

    // Table walk: R2, R3, R4 gaps, R5 coincident strobe, R6 lone strobe, R9 hold
    foreach (VEC[k]) step(VEC[k][2], VEC[k][1], VEC[k][0], "R2/R3/R4/R5/R6/R9 table");

    // R7: first 30 sequence bits with zero data
    step(1'b1, 1'b1, 1'b0, "R7 sequence");
    for (int i = 1; i < 30; i++) step(1'b0, 1'b1, 1'b0, "R7 sequence");

    // R8: whiten then dewhiten
    for (int i = 0; i < 40; i++) begin
      sent[i] = ((i * 7 + 3) % 5) < 2;
      step(i == 0, 1'b1, sent[i], "R8 whiten");
      got[i] = out_bit;
    end
    step(1'b0, 1'b0, 1'b0, "R9 idle");
    for (int i = 0; i < 40; i++) begin
      step(i == 0, 1'b1, got[i], "R8 dewhiten");
      check(out_bit == sent[i], "R8 roundtrip", out_bit, sent[i]);
    end

    // R1: reset mid-stream returns the seed
    step(1'b1, 1'b1, 1'b1, "R5 start");
    step(1'b0, 1'b1, 1'b1, "R2 data");
    @(negedge clk); rst_n = 1'b0; in_valid = 1'b0; burst_start = 1'b0;
    @(posedge clk); #2;
    check(out_valid == 1'b0, "R1 midreset valid", out_valid, 1'b0);
    check(out_bit == 1'b0, "R1 midreset data", out_bit, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    mdl_n = 0; mdl_out = 1'b0;
    step(1'b0, 1'b1, 1'b1, "R1 seed after midreset");
    step(1'b0, 1'b1, 1'b0, "R4 continue");

    finished = 1;
    report();
  end
endmodule